// File: doc/BRIEF.md
# Audio Sample Pulse-Width Modulator with Byte Queue

This block plays back audio by pulse-width modulation. Software writes samples through a 16-bit write port that has two byte lanes. A write on both lanes holds two 8-bit samples. A write on the low lane alone holds one sample. Accepted samples are placed, one byte per entry, in a small first-in first-out queue.

An 8-bit counter sets the length of each modulation period. At the end of every period the block takes the oldest queued byte and uses it as the duty value for the next period. When the queue runs dry, the output keeps repeating the last duty value. A write that does not fit is dropped and sets a sticky flag. Software clears that flag with a read strobe.

Top module: `audio_sample_pwm`

## Requirements
- R1: A write with `wrByteEn` = 2'b11 queues `wrData[15:8]` first and `wrData[7:0]` second, so the high byte is played one period before the low byte.
- R2: A write with `wrByteEn` = 2'b01 queues only `wrData[7:0]`. A write with `wrByteEn` = 2'b10 or 2'b00 queues nothing and does not touch the overflow flag.
- R3: Acceptance is judged on the queue occupancy at the start of the cycle, and a byte popped in the same cycle is not counted as free. A two-byte write needs two free entries and a one-byte write needs one. A write that does not fit queues nothing and sets `ovfFlag`. The flag stays set until the cycle after `ovfRead` is high. If a new overflow and `ovfRead` fall in the same cycle, the flag stays set.
- R4: While enabled, the counter steps 0, 1, …, `period` and then returns to 0. `pwmOut` is high from count 0 and goes low in the cycle the count equals the duty value, so the output is high while count < duty. A duty of 0 keeps the output low.
- R5: A duty value greater than `period` keeps `pwmOut` high for the whole period, so there is no reset edge.
- R6: A byte is popped only in the cycle where the count equals `period` and the queue is not empty. The new duty takes effect from the following count 0 and does not change inside a period.
- R7: If the queue is empty at the end of a period, the previous duty value is kept and played again.
- R8: While `enable` is low, `pwmOut` is low, the counter is held at 0, the queue is emptied, the duty value returns to 0, and writes are ignored (nothing is queued and no overflow is flagged).
- R9: `fifoEmpty` is high exactly when no byte is queued. `fifoNotFull` is high exactly when fewer than 4 (DEPTH) bytes are queued. Both follow the occupancy in the cycle after each push or pop.
- R10: After reset, the queue is empty, `ovfFlag` is low, the duty value is 0 and `pwmOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the modulator; low flushes the queue and parks the output |
| period | input | 8 | Last count value of a modulation period |
| wrStrobe | input | 1 | Sample write strobe |
| wrByteEn | input | 2 | Byte-lane enables: bit 1 for bits 15–8, bit 0 for bits 7–0 |
| wrData | input | 16 | Sample write data |
| ovfRead | input | 1 | Read strobe that clears the overflow flag |
| pwmOut | output | 1 | Modulated output |
| fifoEmpty | output | 1 | No sample is queued |
| fifoNotFull | output | 1 | At least one queue entry is free |
| ovfFlag | output | 1 | Sticky flag: a write was dropped |

## Verification
The collision of interest is a sample write landing in the same cycle as the end-of-period pop. In that cycle the write must be judged on the occupancy before the pop, while the pop removes the head byte. To provoke it, the bench writes a byte on every cycle for longer than several short periods, with the queue close to full. Many writes therefore coincide with a wrap, and some find the queue exactly full. A bench-side model applies the acceptance rule from the requirements and decides which bytes enter the queue. It then compares, every cycle, the output level, both status flags and the overflow flag against its own queue. A wrong acceptance decision shows up periods later as a wrong duty value or a wrong flag.

// File: rtl/audio_pwm_pkg.sv
package audio_pwm_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic pushHi;  // queue the high lane ahead of the low lane
    logic pushLo;  // queue the low lane
    logic pop;     // load the head byte as the next duty value
    logic flush;   // empty the queue and clear the duty value
    logic ovfSet;  // a write was refused
    logic outEn;   // modulator running
  } pwm_strobe_t;

endpackage

// File: rtl/apf_ctrl.sv
module apf_ctrl
  import audio_pwm_pkg::*;
#(
  parameter int SW    = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [SW-1:0] period,
  input  logic          wrStrobe,
  input  logic [1:0]    wrByteEn,
  input  logic [CW-1:0] fifoCount,
  output logic [SW-1:0] cnt,
  output pwm_strobe_t   strobe
);

  localparam logic [CW-1:0] DepthC = CW'(DEPTH);

  logic [1:0]    needSlots;
  logic [CW-1:0] freeSlots;
  logic          wrValid;
  logic          wrAccept;
  logic          atWrap;

  always_comb begin
    unique case (wrByteEn)
      2'b11:   needSlots = 2'd2;
      2'b01:   needSlots = 2'd1;
      default: needSlots = 2'd0;
    endcase
  end

  assign freeSlots = DepthC - fifoCount;
  assign wrValid   = enable && wrStrobe && (needSlots != 2'd0);
  assign wrAccept  = wrValid && (freeSlots >= CW'(needSlots));
  assign atWrap    = (cnt == period);

  always_comb begin
    strobe        = '0;
    strobe.outEn  = enable;
    strobe.flush  = !enable;
    strobe.pushLo = wrAccept;
    strobe.pushHi = wrAccept && (needSlots == 2'd2);
    strobe.ovfSet = wrValid && !wrAccept;
    strobe.pop    = enable && atWrap && (fifoCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!enable) begin
      cnt <= '0;
    end else if (atWrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + SW'(1);
    end
  end

endmodule

// File: rtl/apf_datapath.sv
module apf_datapath
  import audio_pwm_pkg::*;
#(
  parameter int SW    = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  pwm_strobe_t     strobe,
  input  logic [2*SW-1:0] wrData,
  input  logic            ovfRead,
  input  logic [SW-1:0]   cnt,
  output logic [CW-1:0]   fifoCount,
  output logic [SW-1:0]   duty,
  output logic            pwmOut,
  output logic            fifoEmpty,
  output logic            fifoNotFull,
  output logic            ovfFlag
);

  // DEPTH must be a power of two so pointers wrap naturally
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  typedef logic [PW-1:0] ptr_t;

  logic [SW-1:0] slotMem [DEPTH];
  ptr_t          wrPtr;
  ptr_t          rdPtr;
  logic [SW-1:0] hiByte;
  logic [SW-1:0] loByte;
  logic [CW-1:0] pushCount;

  assign hiByte    = wrData[2*SW-1:SW];
  assign loByte    = wrData[SW-1:0];
  assign pushCount = CW'(strobe.pushHi) + CW'(strobe.pushLo);

  always_ff @(posedge clk) begin
    if (!strobe.flush) begin
      if (strobe.pushHi) begin
        slotMem[wrPtr]             <= hiByte;
        slotMem[wrPtr + ptr_t'(1)] <= loByte;
      end else if (strobe.pushLo) begin
        slotMem[wrPtr] <= loByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      duty      <= '0;
    end else if (strobe.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      duty      <= '0;
    end else begin
      if (strobe.pop) begin
        duty  <= slotMem[rdPtr];
        rdPtr <= rdPtr + ptr_t'(1);
      end
      wrPtr     <= wrPtr + ptr_t'(pushCount);
      fifoCount <= fifoCount + pushCount - CW'(strobe.pop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (strobe.ovfSet) begin
      ovfFlag <= 1'b1;
    end else if (ovfRead) begin
      ovfFlag <= 1'b0;
    end
  end

  assign pwmOut      = strobe.outEn && (cnt < duty);
  assign fifoEmpty   = (fifoCount == '0);
  assign fifoNotFull = (fifoCount < CW'(DEPTH));

endmodule

// File: rtl/audio_sample_pwm.sv
module audio_sample_pwm
  import audio_pwm_pkg::*;
#(
  parameter int SW    = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [SW-1:0]   period,
  input  logic            wrStrobe,
  input  logic [1:0]      wrByteEn,
  input  logic [2*SW-1:0] wrData,
  input  logic            ovfRead,
  output logic            pwmOut,
  output logic            fifoEmpty,
  output logic            fifoNotFull,
  output logic            ovfFlag
);

  localparam int CW = $clog2(DEPTH + 1);

  pwm_strobe_t   strobe;
  logic [CW-1:0] fifoCount;
  logic [SW-1:0] cnt;
  logic [SW-1:0] duty;

  apf_ctrl #(.SW(SW), .DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .period    (period),
    .wrStrobe  (wrStrobe),
    .wrByteEn  (wrByteEn),
    .fifoCount (fifoCount),
    .cnt       (cnt),
    .strobe    (strobe)
  );

  apf_datapath #(.SW(SW), .DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .ovfRead     (ovfRead),
    .cnt         (cnt),
    .fifoCount   (fifoCount),
    .duty        (duty),
    .pwmOut      (pwmOut),
    .fifoEmpty   (fifoEmpty),
    .fifoNotFull (fifoNotFull),
    .ovfFlag     (ovfFlag)
  );

endmodule

// File: rtl/apf_checker.sv
module apf_checker #(
  parameter int SW    = 8,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          enable,
  input logic [SW-1:0] period,
  input logic          wrStrobe,
  input logic [1:0]    wrByteEn,
  input logic          pwmOut,
  input logic          fifoEmpty,
  input logic          fifoNotFull,
  input logic          ovfFlag,
  input logic [SW-1:0] cnt,
  input logic [SW-1:0] duty
);

  AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cnt == '0 && duty != '0) |-> pwmOut); // R4

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (enable && duty > period) |-> pwmOut); // R5

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cnt != '0) |-> $stable(duty)); // R6

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrStrobe && wrByteEn == 2'b01 && !fifoNotFull) |=> ovfFlag); // R3

  AST_OFF_FLUSHES: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (fifoEmpty && !pwmOut)); // R8

  AST_FLAGS_CONSISTENT: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> fifoNotFull); // R9

endmodule

bind audio_sample_pwm apf_checker #(.SW(SW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .period      (period),
  .wrStrobe    (wrStrobe),
  .wrByteEn    (wrByteEn),
  .pwmOut      (pwmOut),
  .fifoEmpty   (fifoEmpty),
  .fifoNotFull (fifoNotFull),
  .ovfFlag     (ovfFlag),
  .cnt         (cnt),
  .duty        (duty)
);

// File: tb/sim_audio_sample_pwm.sv
module sim_audio_sample_pwm;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  period = 8'd5;
  logic        wrStrobe = 1'b0;
  logic [1:0]  wrByteEn = 2'b00;
  logic [15:0] wrData = 16'h0000;
  logic        ovfRead = 1'b0;
  wire         pwmOut, fifoEmpty, fifoNotFull, ovfFlag;

  always #5 clk = ~clk;

  audio_sample_pwm u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .period(period),
    .wrStrobe(wrStrobe), .wrByteEn(wrByteEn), .wrData(wrData),
    .ovfRead(ovfRead), .pwmOut(pwmOut), .fifoEmpty(fifoEmpty),
    .fifoNotFull(fifoNotFull), .ovfFlag(ovfFlag)
  );

  int    nChecks = 0;
  int    nFail = 0;
  string phase = "R10";

  // Scoreboard: expected queue contents and current duty
  byte unsigned expQ[$];
  int           curDuty = 0;
  int           tbCnt = 0;
  bit           tbOvf = 1'b0;

  task automatic check(input bit got, input bit exp, input string tag, input string what);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, got, exp, $time);
    end
  endtask

  // Reference model, updated at each clock edge from the requirements
  int occ, need;
  bit setOvf;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expQ.delete(); curDuty = 0; tbCnt = 0; tbOvf = 1'b0;
    end else if (!enable) begin
      expQ.delete(); curDuty = 0; tbCnt = 0;           // R8
      if (ovfRead) tbOvf = 1'b0;
    end else begin
      occ = expQ.size();
      need = (wrByteEn == 2'b11) ? 2 : (wrByteEn == 2'b01) ? 1 : 0;  // R2
      setOvf = 1'b0;
      if (tbCnt == int'(period) && occ > 0) curDuty = expQ.pop_front(); // R6, R7
      if (wrStrobe && need > 0) begin
        if (DEPTH - occ >= need) begin                 // R3: occupancy before pop
          if (need == 2) expQ.push_back(wrData[15:8]); // R1: high byte first
          expQ.push_back(wrData[7:0]);
        end else setOvf = 1'b1;
      end
      if (setOvf) tbOvf = 1'b1;
      else if (ovfRead) tbOvf = 1'b0;
      tbCnt = (tbCnt == int'(period)) ? 0 : tbCnt + 1;
    end
  end

  // Monitor: compare outputs 2 ns after each edge
  always begin
    @(posedge clk);
    #2;
    check(pwmOut, enable && (tbCnt < curDuty), phase, "pwmOut");
    check(fifoEmpty, expQ.size() == 0, "R9", "fifoEmpty");
    check(fifoNotFull, expQ.size() < DEPTH, "R9", "fifoNotFull");
    check(ovfFlag, tbOvf, "R3", "ovfFlag");
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wrData = d; wrByteEn = be; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; wrByteEn = 2'b00;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R10: reset state
    idle(3);
    check(pwmOut, 1'b0, "R10", "pwmOut in reset");
    check(fifoEmpty, 1'b1, "R10", "fifoEmpty in reset");
    check(ovfFlag, 1'b0, "R10", "ovfFlag in reset");
    rstN = 1'b1;
    idle(2);

    phase = "R4";  enable = 1'b1; wr(16'h0003, 2'b01); idle(24);
    phase = "R1";  wr(16'h0204, 2'b11); idle(24);
    phase = "R7";  idle(18);
    phase = "R2";  wr(16'h0500, 2'b10); wr(16'h0700, 2'b00); idle(12);
                   wr(16'h0901, 2'b01); idle(18);
    phase = "R5";  wr(16'h06C8, 2'b11); wr(16'h0000, 2'b01); idle(30);

    // R3: writes every cycle, colliding with end-of-period pops
    phase = "R3";
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wrData = {8'(i % 6), 8'((i + 2) % 6)};
      wrByteEn = (i % 3 == 0) ? 2'b11 : 2'b01;
      wrStrobe = 1'b1;
    end
    @(negedge clk); wrStrobe = 1'b0; wrByteEn = 2'b00;
    idle(3);
    @(negedge clk); ovfRead = 1'b1;
    @(negedge clk); ovfRead = 1'b0;
    for (int i = 0; i < 5; i++) wr(16'h0002, 2'b01);
    @(negedge clk); ovfRead = 1'b1; wrData = 16'h0004; wrByteEn = 2'b01; wrStrobe = 1'b1;
    @(negedge clk); ovfRead = 1'b0; wrStrobe = 1'b0; wrByteEn = 2'b00;
    idle(40);

    // R8: disable with a loaded queue, write while off
    phase = "R8";
    wr(16'h0304, 2'b11);
    idle(2);
    @(negedge clk); enable = 1'b0;
    wr(16'h0102, 2'b11); wr(16'h0001, 2'b01); idle(4);
    period = 8'd2;

    // R6: short period, back-to-back samples
    phase = "R6";
    @(negedge clk); enable = 1'b1;
    for (int i = 1; i < 5; i++) begin
      @(negedge clk);
      wrData = 16'(i % 4); wrByteEn = 2'b01; wrStrobe = 1'b1;
    end
    @(negedge clk); wrStrobe = 1'b0; wrByteEn = 2'b00;
    idle(30);

    finishRun();
  end

endmodule